// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Automatic Clock Wait

This block is a full-duplex, byte-wide synchronous serial shifter that a processor drives through a small register interface. It holds one transmit buffer and one receive buffer, a control register (run, inhibit, clock source) and a status register. Each frame moves one byte out on `so` and one byte in from `si` at the same time.

With the internal clock source, the block makes the serial clock itself from the system clock. It pauses that clock, held high, whenever software has fallen behind. With the external clock source, the serial clock arrives on `sck_in`. Software cannot hold back an outside master, so in this mode the block records sticky underrun and overrun errors. Operation ends in one of two ways. A soft stop lets the frame in progress finish. An inhibit cuts the frame off and returns the unit to its cleared state.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Register map: address 0 is data (write loads the transmit buffer, read returns the receive buffer), address 1 is control, address 2 is status. Status bit 0 (TXE) is set when the transmit buffer is empty and bit 1 (RXF) is set when the receive buffer is full. A data write clears TXE and a data read clears RXF. After reset, status reads 0x01 and control reads 0x00.
- R2: A frame is 8 bits, MSB first. SO changes when SCK falls and SI is sampled when SCK rises. SCK idles high. In internal mode each SCK half period lasts HALF_DIV system clocks. The received byte is read at address 0.
- R3: In internal mode, once a frame ends, SCK stays high while the received byte is unread or the next byte is unwritten, in either order.
- R4: Once the second of those two accesses is done, the first SCK fall comes within 2*HALF_DIV+2 system clocks.
- R5: With control bit 2 set, frames are clocked by `sck_in` through a two-stage synchronizer, with the same bit order and edge use as R2.
- R6: In external mode, a frame that begins while TXE is set raises status bit 2 (TXERR).
- R7: In external mode, a frame that completes while RXF is still set raises status bit 3 (RXERR) and overwrites the receive buffer. TXERR and RXERR stay set until inhibit or reset.
- R8: Clearing control bit 0 (run) during a frame lets that frame complete. After that, status bit 4 (busy) is clear, SO is high and no new frame starts. Status bit 5 is set while a frame is shifting.
- R9: Writing control bit 1 (inhibit) halts at once: from the next clock, SCK and SO are high, run is clear, status reads 0x01 and the receive buffer reads 0. All of this holds, and data writes are ignored, for as long as the bit stays set.
- R10: Control reads back as {bit2 ext, bit1 inhibit, bit0 run}. Read data is registered and is valid on the clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Generated serial clock, idle high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
The internal mode is run with a table of bytes under two patterns: a straight loopback, where received equals sent, and an inverted loopback, where received is the complement of sent. Together they separate the transmit shift path from the receive shift path. The table holds all-zero, all-one, alternating and edge-bit bytes, which expose errors in bit order, in edge choice and in the final bit. Auto-wait is tried in both access orders, and each order checks both that SCK is held and how soon it resumes. External frames are run three ways: with a byte written first, without a write, and without a read. These tell the underrun flag, the overrun flag and their persistence apart.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam int CB_RUN = 0;
  localparam int CB_INH = 1;
  localparam int CB_EXT = 2;

  localparam int SB_TXE   = 0;
  localparam int SB_RXF   = 1;
  localparam int SB_TXERR = 2;
  localparam int SB_RXERR = 3;
  localparam int SB_BUSY  = 4;
  localparam int SB_SHIFT = 5;
endpackage

// File: rtl/ssx_sync2edge.sv
module ssx_sync2edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = ~prev & chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/ssx_halfdiv.sv
module ssx_halfdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en & (cnt == LAST);
endmodule

// File: rtl/ssx_shift_core.sv
module ssx_shift_core #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ext_mode,
  input  logic              run,
  input  logic              go_ok,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              si,
  input  logic              ext_fall,
  input  logic              ext_rise,
  output logic              sck_out,
  output logic              so,
  output logic              active,
  output logic              load_stb,
  output logic              done_stb,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              loaded;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] txsh;
  logic [DATA_W-2:0] rxsh;
  logic              sck_int;
  logic              tick;
  logic              fall_ev, rise_ev;
  logic              start_int, start_ext;
  logic              shift_stb, sample_stb, last_bit;

  ssx_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst  (rst | clr),
    .en   (active & ~ext_mode),
    .tick (tick)
  );

  always_comb begin
    fall_ev    = ext_mode ? ext_fall : (tick & sck_int);
    rise_ev    = ext_mode ? ext_rise : (tick & ~sck_int);
    start_int  = ~active & ~ext_mode & run & go_ok;
    start_ext  = ~active & ext_mode & run & ext_fall;
    load_stb   = start_ext | (active & ~loaded & fall_ev);
    shift_stb  = active & loaded & fall_ev;
    sample_stb = active & loaded & rise_ev;
    last_bit   = (bitcnt == LAST_BIT);
    done_stb   = sample_stb & last_bit;
    rx_data    = {rxsh, si};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active  <= 1'b0;
      loaded  <= 1'b0;
      bitcnt  <= '0;
      txsh    <= '1;
      rxsh    <= '0;
      sck_int <= 1'b1;
    end else begin
      if (!active || ext_mode) sck_int <= 1'b1;
      else if (tick)           sck_int <= ~sck_int;

      if (start_int) begin
        active <= 1'b1;
        loaded <= 1'b0;
        bitcnt <= '0;
      end

      if (load_stb) begin
        active <= 1'b1;
        loaded <= 1'b1;
        bitcnt <= '0;
        txsh   <= tx_data;
      end else if (shift_stb) begin
        txsh <= {txsh[DATA_W-2:0], 1'b1};
      end

      if (sample_stb) begin
        rxsh   <= rx_data[DATA_W-2:0];
        bitcnt <= bitcnt + 1'b1;
        if (last_bit) begin
          active <= 1'b0;
          loaded <= 1'b0;
          txsh   <= '1;
        end
      end
    end
  end

  assign sck_out = sck_int;
  assign so      = txsh[DATA_W-1];

  // R3: no frame may begin while software is behind, so the clock stays high
  a_r3_wait_keeps_sck_high: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && !active && !go_ok) |=> sck_out);

  // R8: the data line rests high between frames
  a_r8_idle_so_high: assert property (@(posedge clk) disable iff (rst)
    !active |-> so);

  // R8: with run clear, an idle unit stays idle
  a_r8_no_start_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !active) |=> !active);

  // R2: a finished frame leaves the serial clock high
  a_r2_done_sck_high: assert property (@(posedge clk) disable iff (rst)
    (done_stb && !ext_mode) |=> sck_out);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              so,
  input  logic              si
);
  import ssx_pkg::*;

  logic              run_q, inh_q, ext_q;
  logic [DATA_W-1:0] txbuf, rxbuf;
  logic              tx_empty, rx_full, tx_err, rx_err;
  logic              ctrl_wr, inh_wr, data_wr, data_rd, core_clr, go_ok;
  logic              ext_rise, ext_fall;
  logic              active, load_stb, done_stb;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] stat_word, ctrl_word;

  always_comb begin
    ctrl_wr  = wr_en & (addr == A_CTRL);
    inh_wr   = ctrl_wr & wdata[CB_INH];
    data_wr  = wr_en & (addr == A_DATA);
    data_rd  = rd_en & (addr == A_DATA);
    core_clr = inh_q | inh_wr;
    go_ok    = ~tx_empty & ~rx_full;
  end

  ssx_sync2edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sck_in),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  ssx_shift_core #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_core (
    .clk      (clk),
    .rst      (rst),
    .clr      (core_clr),
    .ext_mode (ext_q),
    .run      (run_q),
    .go_ok    (go_ok),
    .tx_data  (txbuf),
    .si       (si),
    .ext_fall (ext_fall),
    .ext_rise (ext_rise),
    .sck_out  (sck_out),
    .so       (so),
    .active   (active),
    .load_stb (load_stb),
    .done_stb (done_stb),
    .rx_data  (rx_data)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[SB_TXE]   = tx_empty;
    stat_word[SB_RXF]   = rx_full;
    stat_word[SB_TXERR] = tx_err;
    stat_word[SB_RXERR] = rx_err;
    stat_word[SB_BUSY]  = run_q | active;
    stat_word[SB_SHIFT] = active;
    ctrl_word           = '0;
    ctrl_word[CB_RUN]   = run_q;
    ctrl_word[CB_INH]   = inh_q;
    ctrl_word[CB_EXT]   = ext_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      inh_q    <= 1'b0;
      ext_q    <= 1'b0;
      txbuf    <= '0;
      rxbuf    <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      tx_err   <= 1'b0;
      rx_err   <= 1'b0;
      rdata    <= '0;
    end else begin
      if (ctrl_wr) begin
        inh_q <= wdata[CB_INH];
        ext_q <= wdata[CB_EXT];
        run_q <= wdata[CB_RUN] & ~wdata[CB_INH];
      end

      if (core_clr) begin
        txbuf    <= '0;
        rxbuf    <= '0;
        tx_empty <= 1'b1;
        rx_full  <= 1'b0;
        tx_err   <= 1'b0;
        rx_err   <= 1'b0;
      end else begin
        if (load_stb) begin
          tx_empty <= 1'b1;
          if (ext_q && tx_empty) tx_err <= 1'b1;
        end
        if (data_wr) begin
          txbuf    <= wdata;
          tx_empty <= 1'b0;
        end
        if (data_rd) rx_full <= 1'b0;
        if (done_stb) begin
          rxbuf   <= rx_data;
          rx_full <= 1'b1;
          if (rx_full) rx_err <= 1'b1;
        end
      end

      if (rd_en) begin
        case (addr)
          A_DATA:  rdata <= rxbuf;
          A_CTRL:  rdata <= ctrl_word;
          A_STAT:  rdata <= stat_word;
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R1: a data write leaves the transmit buffer marked full
  a_r1_txe_cleared_by_write: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !core_clr) |=> !tx_empty);

  // R1: a data read with no frame landing leaves the receive buffer empty
  a_r1_rxf_cleared_by_read: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !done_stb && !core_clr) |=> !rx_full);

  // R9: a held inhibit keeps the unit cleared and the lines high
  a_r9_inhibit_holds_clear: assert property (@(posedge clk) disable iff (rst)
    (inh_q && !ctrl_wr) |=> (!run_q && tx_empty && !rx_full && !tx_err &&
                             !rx_err && sck_out && so && rxbuf == '0));

  // R7: error flags are sticky outside inhibit
  a_r7_txerr_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !core_clr) |=> tx_err);

  a_r7_rxerr_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_err && !core_clr) |=> rx_err);
endmodule

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  import ssx_pkg::*;

  localparam int HD = 4;
  localparam int EH = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sck_in = 1'b1;
  logic       sck_out, so, si;
  logic       use_lb = 1'b1, inv_lb = 1'b0, si_drv = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  assign si = use_lb ? (so ^ inv_lb) : si_drv;

  always #4 clk = ~clk;

  sync_serial_xcvr #(.DATA_W(8), .HALF_DIV(HD)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_in(sck_in), .sck_out(sck_out),
    .so(so), .si(si)
  );

  // bit 8 selects inverted loopback, bits 7:0 are the byte sent
  localparam logic [8:0] VEC [0:5] = '{9'h0A5, 9'h15A, 9'h000, 9'h1FF, 9'h081, 9'h13C};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic int_frame(output logic [7:0] cap);
    int   rises = 0;
    logic prev  = sck_out;
    logic last  = so;
    cap = 8'h00;
    for (int t = 0; t < 2000 && rises < 8; t++) begin
      @(negedge clk);
      if (sck_out == 1'b0) last = so;
      if (!prev && sck_out) begin cap = {cap[6:0], last}; rises++; end
      prev = sck_out;
    end
  endtask

  task automatic count_to_fall(output int cyc);
    cyc = 0;
    while (sck_out !== 1'b0 && cyc < 500) begin @(negedge clk); cyc++; end
  endtask

  task automatic watch_high(input int n, output int lows);
    lows = 0;
    for (int t = 0; t < n; t++) begin @(negedge clk); if (sck_out !== 1'b1) lows++; end
  endtask

  task automatic ext_frame(input logic [7:0] sib, output logic [7:0] cap);
    cap = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); sck_in = 1'b0; si_drv = sib[b];
      repeat (EH) @(negedge clk);
      cap = {cap[6:0], so}; sck_in = 1'b1;
      repeat (EH) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, cap;
    int         c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state: R1, R10, R2
    reg_rd(A_STAT, v); chk("R1 reset status", v, 8'h01);
    reg_rd(A_CTRL, v); chk("R10 reset control", v, 8'h00);
    chk("R2 sck idle high", sck_out, 1);
    chk("R8 so idle high", so, 1);
    reg_wr(A_CTRL, 8'h01);
    reg_rd(A_CTRL, v); chk("R10 control readback", v, 8'h01);

    // table walk, internal clock: R2 R1
    for (int i = 0; i < 6; i++) begin
      inv_lb = VEC[i][8];
      reg_wr(A_DATA, VEC[i][7:0]);
      int_frame(cap);
      chk("R2 so bit order", cap, VEC[i][7:0]);
      repeat (4) @(negedge clk);
      reg_rd(A_STAT, v); chk("R1 status after frame", v, 8'h13);
      reg_rd(A_DATA, v); chk("R2 received byte", v, VEC[i][7:0] ^ {8{VEC[i][8]}});
    end
    inv_lb = 1'b0;

    // auto-wait, read then write: R3 R4
    reg_wr(A_DATA, 8'h3C);
    int_frame(cap);
    repeat (4) @(negedge clk);
    reg_rd(A_DATA, v); chk("R2 byte 3C", v, 8'h3C);
    watch_high(60, c); chk("R3 held after read only", c, 0);
    reg_wr(A_DATA, 8'hC3);
    count_to_fall(c); chk("R4 resume after write", (c <= 2*HD+2) ? 1 : 0, 1);
    int_frame(cap); chk("R2 so byte C3", cap, 8'hC3);
    repeat (4) @(negedge clk);

    // auto-wait, write then read: R3 R4
    reg_wr(A_DATA, 8'h5A);
    watch_high(60, c); chk("R3 held after write only", c, 0);
    reg_rd(A_DATA, v); chk("R2 byte C3 rx", v, 8'hC3);
    count_to_fall(c); chk("R4 resume after read", (c <= 2*HD+2) ? 1 : 0, 1);
    int_frame(cap); chk("R2 so byte 5A", cap, 8'h5A);
    repeat (4) @(negedge clk);
    reg_rd(A_DATA, v); chk("R2 byte 5A rx", v, 8'h5A);

    // graceful stop: R8
    reg_wr(A_DATA, 8'h96);
    count_to_fall(c);
    reg_wr(A_CTRL, 8'h00);
    reg_rd(A_STAT, v); chk("R8 busy during stop", v, 8'h31);
    repeat (100) @(negedge clk);
    reg_rd(A_STAT, v); chk("R8 idle after stop", v, 8'h03);
    reg_rd(A_DATA, v); chk("R8 frame completed", v, 8'h96);
    reg_wr(A_DATA, 8'h11);
    watch_high(60, c); chk("R8 no new frame", c, 0);
    chk("R8 so high after stop", so, 1);
    reg_rd(A_STAT, v); chk("R1 status pending tx", v, 8'h00);

    // inhibit: R9
    reg_wr(A_CTRL, 8'h01);
    count_to_fall(c);
    repeat (10) @(negedge clk);
    reg_wr(A_CTRL, 8'h02);
    chk("R9 sck high at once", sck_out, 1);
    chk("R9 so high at once", so, 1);
    watch_high(40, c); chk("R9 sck held", c, 0);
    reg_rd(A_CTRL, v); chk("R9 run cleared", v, 8'h02);
    reg_rd(A_STAT, v); chk("R9 status cleared", v, 8'h01);
    reg_rd(A_DATA, v); chk("R9 rx buffer cleared", v, 8'h00);
    reg_wr(A_DATA, 8'h77);
    reg_rd(A_STAT, v); chk("R9 write ignored", v, 8'h01);
    reg_wr(A_CTRL, 8'h00);
    reg_rd(A_STAT, v); chk("R9 released", v, 8'h01);

    // external clock: R5 R6 R7
    use_lb = 1'b0;
    reg_wr(A_CTRL, 8'h05);
    reg_wr(A_DATA, 8'hB2);
    ext_frame(8'h4E, cap); chk("R5 ext so byte", cap, 8'hB2);
    reg_rd(A_STAT, v); chk("R5 ext status", v, 8'h13);
    reg_rd(A_DATA, v); chk("R5 ext rx byte", v, 8'h4E);
    reg_rd(A_STAT, v); chk("R1 rxf cleared", v, 8'h11);
    ext_frame(8'h81, cap);
    reg_rd(A_STAT, v); chk("R6 underrun flag", v, 8'h17);
    ext_frame(8'h66, cap);
    reg_rd(A_STAT, v); chk("R7 overrun flag", v, 8'h1F);
    reg_rd(A_DATA, v); chk("R7 overwrite", v, 8'h66);
    reg_rd(A_STAT, v); chk("R7 errors sticky", v, 8'h1D);
    reg_wr(A_CTRL, 8'h02);
    reg_rd(A_STAT, v); chk("R7 cleared by inhibit", v, 8'h01);
    reg_wr(A_CTRL, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule